// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the word address presented to a synchronous burst memory. When a burst begins, the full external address is captured. From then on, only the lowest address bits move. Each cycle that the advance input is asserted steps them to the next position of a four-beat group. The upper bits stay frozen at the value captured when the burst began.

The step order is chosen by a mode input. With the mode low, the low bits count upward modulo four from the start value. With the mode high, the low bits are the start value XOR the beat number. Two address strobes can start a burst. The processor strobe is qualified by an active-low select. The controller strobe is not qualified. The block reports the current address and the beat number within the burst.

Top module: `burst_addr_seq`

## Requirements
- R1: Between loads, addr_out[ADDR_W-1:CNT_W] keeps the value of ext_addr[ADDR_W-1:CNT_W] that was captured at the last load.
- R2: With mode_il = 0, each step sets the low field addr_out[CNT_W-1:0] to its previous value plus one, modulo 4. For example, start 2 gives 2, 3, 0, 1.
- R3: With mode_il = 1, after the k-th step the low field equals the captured start value XOR k. For example, start 3 gives 3, 2, 1, 0.
- R4: A load occurs when ctl_stb_n = 0, or when cpu_stb_n = 0 with sel_n = 0. One cycle later, addr_out equals the captured ext_addr and burst_idx = 0. A load takes precedence over adv_n.
- R5: When no load occurs and adv_n = 0, burst_idx increments by one.
- R6: When no load occurs and adv_n = 1, addr_out and burst_idx are unchanged.
- R7: A low cpu_stb_n is ignored while sel_n = 1. A low ctl_stb_n loads regardless of sel_n.
- R8: mode_il is sampled on each step. Changing it mid-burst alters only the steps taken after the change, and never the address already presented.
- R9: After the fourth beat, a further step wraps to the first address of the same group of four, and burst_idx returns to 0.
- R10: While rst_n = 0, addr_out and burst_idx are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_addr | input | ADDR_W | External address captured on a load |
| cpu_stb_n | input | 1 | Processor address strobe, active low, qualified by sel_n |
| ctl_stb_n | input | 1 | Controller address strobe, active low, unqualified |
| sel_n | input | 1 | Primary select, active low; masks cpu_stb_n when high |
| adv_n | input | 1 | Advance, active low |
| mode_il | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_out | output | ADDR_W | Current word address |
| burst_idx | output | CNT_W | Beat number within the burst |

## Verification
The bench builds the block with ADDR_W = 10 and CNT_W = 2. The ten-bit address keeps random upper fields short, so mistakes in freezing or recapturing them show up across many loads. The two-bit counter matches the four-beat group, so every wrap, both step orders and all four start values are reached within a few thousand random cycles. Directed runs cover the following cases:
- a processor strobe masked by the select;
- a controller strobe with the select inactive;
- a mode flip in the middle of a burst.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              cpu_stb_n,
  input  logic              ctl_stb_n,
  input  logic              sel_n,
  input  logic              adv_n,
  input  logic              mode_il,
  output logic [ADDR_W-1:0] addr_out,
  output logic [CNT_W-1:0]  burst_idx
);
  localparam int HI_W = ADDR_W - CNT_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [HI_W-1:0]  hi_q;
  logic [CNT_W-1:0] start_q, low_q, idx_q, idx_nx;
  logic             load;

  assign load   = ~ctl_stb_n | (~cpu_stb_n & ~sel_n);
  assign idx_nx = idx_q + ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
      low_q   <= '0;
      idx_q   <= '0;
    end else if (load) begin
      hi_q    <= ext_addr[ADDR_W-1:CNT_W];
      start_q <= ext_addr[CNT_W-1:0];
      low_q   <= ext_addr[CNT_W-1:0];
      idx_q   <= '0;
    end else if (!adv_n) begin
      idx_q <= idx_nx;
      low_q <= mode_il ? (start_q ^ idx_nx) : (low_q + ONE);
    end
  end

  assign addr_out  = {hi_q, low_q};
  assign burst_idx = idx_q;

  // R4
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (burst_idx == '0) && (addr_out == $past(ext_addr)));

  // R1
  upper_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(addr_out[ADDR_W-1:CNT_W]));

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n) |=> burst_idx == $past(burst_idx) + ONE);

  // R6
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv_n) |=> $stable(addr_out) && $stable(burst_idx));

  // R2
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n && !mode_il) |=>
      addr_out[CNT_W-1:0] == $past(addr_out[CNT_W-1:0]) + ONE);

  // R7
  cpu_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stb_n && sel_n && ctl_stb_n && adv_n) |=> $stable(addr_out));

  // R10
  always @(negedge clk)
    if (!rst_n && $past(!rst_n))
      reset_zero_chk: assert (addr_out == '0 && burst_idx == '0);
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 10;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] ext_addr;
  logic          cpu_stb_n, ctl_stb_n, sel_n, adv_n, mode_il;
  logic [AW-1:0] addr_out;
  logic [CW-1:0] burst_idx;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [AW-CW-1:0] m_hi;
  logic [CW-1:0]    m_start, m_low, m_idx;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .cpu_stb_n(cpu_stb_n),
    .ctl_stb_n(ctl_stb_n), .sel_n(sel_n), .adv_n(adv_n), .mode_il(mode_il),
    .addr_out(addr_out), .burst_idx(burst_idx));

  function automatic logic [AW-1:0] exp_addr();
    return {m_hi, m_low};
  endfunction

  task automatic check(input string tag);
    checks++;
    if (addr_out !== exp_addr() || burst_idx !== m_idx) begin
      errors++;
      $display("FAIL %s: addr=%h idx=%0d expected addr=%h idx=%0d",
               tag, addr_out, burst_idx, exp_addr(), m_idx);
    end
  endtask

  task automatic cyc(input logic [AW-1:0] a, input logic cpu, input logic ctl,
                     input logic sel, input logic adv, input logic md,
                     input string tag);
    ext_addr = a; cpu_stb_n = cpu; ctl_stb_n = ctl; sel_n = sel;
    adv_n = adv; mode_il = md;
    @(posedge clk);
    if (!ctl || (!cpu && !sel)) begin
      m_hi = a[AW-1:CW]; m_start = a[CW-1:0]; m_low = a[CW-1:0]; m_idx = '0;
    end else if (!adv) begin
      m_idx = m_idx + 1'b1;
      m_low = md ? (m_start ^ m_idx) : CW'(m_low + 1'b1);
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 0; ext_addr = 10'h3FF; cpu_stb_n = 0; ctl_stb_n = 0;
    sel_n = 0; adv_n = 0; mode_il = 1;
    m_hi = '0; m_start = '0; m_low = '0; m_idx = '0;
    repeat (3) @(negedge clk);
    check("R10");
    rst_n = 1;

    // linear, start 2, wrap
    cyc(10'h2B6, 1, 0, 1, 1, 0, "R4 R7 ctl strobe with sel inactive");
    cyc(10'h000, 1, 1, 0, 0, 0, "R2");
    cyc(10'h000, 1, 1, 0, 0, 0, "R2");
    cyc(10'h000, 1, 1, 0, 0, 0, "R2");
    cyc(10'h000, 1, 1, 0, 0, 0, "R9 wrap to first");
    cyc(10'h155, 1, 1, 0, 0, 0, "R1 upper held");
    cyc(10'h155, 1, 1, 0, 1, 0, "R6 suspend");
    cyc(10'h155, 1, 1, 0, 1, 1, "R6 suspend");
    // interleaved start 3
    cyc(10'h1C7, 0, 1, 0, 1, 1, "R4 cpu strobe");
    cyc(10'h000, 1, 1, 0, 0, 1, "R3");
    cyc(10'h000, 1, 1, 0, 0, 1, "R3");
    cyc(10'h000, 1, 1, 0, 0, 1, "R3");
    cyc(10'h000, 1, 1, 0, 0, 1, "R9 interleaved wrap");
    // masked cpu strobe
    cyc(10'h0A1, 0, 1, 1, 1, 1, "R7 masked cpu strobe");
    cyc(10'h0A1, 0, 1, 1, 0, 1, "R7 masked cpu strobe steps");
    // load over advance
    cyc(10'h3E9, 0, 1, 0, 0, 1, "R4 load beats advance");
    // mode flip mid-burst, start 1
    cyc(10'h000, 1, 1, 0, 0, 1, "R8 interleaved step");
    cyc(10'h000, 1, 1, 0, 1, 0, "R8 flip while held");
    cyc(10'h000, 1, 1, 0, 0, 0, "R8 linear step");
    cyc(10'h000, 1, 1, 0, 0, 1, "R8 interleaved step");

    for (int i = 0; i < 4000; i++) begin
      logic cpu, ctl, sel, adv, md;
      string tag;
      cpu = ($urandom % 6) != 0;
      ctl = ($urandom % 6) != 0;
      sel = $urandom % 2;
      adv = ($urandom % 4) == 0;
      md  = (($urandom % 20) == 0) ? ~mode_il : mode_il;
      if (!ctl || (!cpu && !sel)) tag = "R4";
      else if (!cpu) tag = "R7";
      else if (!adv) tag = md ? "R3 R5" : "R2 R5";
      else tag = "R6";
      cyc(AW'($urandom), cpu, ctl, sel, adv, md, tag);
    end

    rst_n = 0;
    @(posedge clk);
    m_hi = '0; m_start = '0; m_low = '0; m_idx = '0;
    @(negedge clk);
    check("R10 late reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule